// File: doc/BRIEF.md
# Transfer Byte Counter with Shadow Reload

This block holds the 24-bit byte count that paces a DMA transfer in a SCSI host adapter. Software writes three byte-wide shadow registers. These values stay invisible until a command byte with its DMA flag set is issued. That command copies the shadow into the readable count. When the command code asks for a transfer, the same command also starts a countdown of the transfer length. A programmed count of zero stands for 65536 bytes. The transfer length is the smaller of that count and the number of bytes the bus still expects. While a command is being collected, the length is capped at 32 instead.

Each accepted DMA byte handshake lowers the readable count and the remaining length by one. When the remaining length reaches zero, the block pulses done and sets terminal count. It also flags a bus-service cause, clears all three readable count bytes and raises its interrupt. Until the high count byte has been written after a reset, reads of the high byte return a fixed identification value. A soft-reset command code returns everything to the reset state, just as the hard reset does.

Top module: `xfer_count_top`

## Requirements
- R1: After hard reset, tc, irq, cause_bs, busy, done and dma_mode are 0, left is 0, and the low (rd_sel=0) and mid (rd_sel=1) count bytes read 0.
- R2: A write to a count byte (reg_sel 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16) clears tc at the next edge. The write only changes the shadow byte, so the readable count does not change.
- R3: A command byte with bit 7 set copies the three shadow bytes into the readable count and sets dma_mode. A command byte with bit 7 clear clears dma_mode and stops any active transfer without completing it.
- R4: The high byte (rd_sel=2) reads CHIP_ID until reg_sel=2 has been written since the last hard reset or soft-reset command (code 0x02 in bits 6:0). After that write it reads the readable count bits 23:16.
- R5: A transfer command (bit 7 set, code 0x10) clears tc, sets busy and loads left with min(effective count, xfer_expect). The effective count, which is also loaded into the readable count, is 65536 when the shadow is zero and the shadow value otherwise.
- R6: When cmd_collect is 1 at a transfer command, left is loaded with min(effective count, 32), and xfer_expect is ignored.
- R7: Each cycle with dma_ack while busy lowers left and the readable count by one. dma_ack while not busy changes nothing.
- R8: On the edge where left reaches 0, including a transfer started with length 0, done is 1 for one cycle. At the same edge tc, irq and cause_bs are set, busy is cleared, and all three count bytes read 0.
- R9: irq_clr clears irq and cause_bs and leaves tc unchanged.
- R10: A transfer code issued without bit 7 starts no transfer, and dma_ack then leaves left and the readable count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| reg_wr | input | 1 | Count byte write strobe |
| reg_sel | input | 2 | Count byte select for writes |
| reg_wdata | input | 8 | Count byte write data |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte: bit 7 DMA flag, bits 6:0 code |
| rd_sel | input | 2 | Count byte select for reads |
| rd_data | output | 8 | Selected readable count byte or CHIP_ID |
| xfer_expect | input | 24 | Bytes still expected by the bus phase |
| cmd_collect | input | 1 | A command is being collected (cap 32) |
| dma_ack | input | 1 | One DMA byte handshake accepted |
| irq_clr | input | 1 | Clears interrupt and cause |
| tc | output | 1 | Terminal count status |
| dma_mode | output | 1 | Last command had the DMA flag |
| busy | output | 1 | Transfer in progress |
| left | output | 24 | Remaining transfer length |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt request |
| cause_bs | output | 1 | Bus-service interrupt cause |

## Verification
Every registered result (tc, busy, left, dma_mode, irq, cause_bs, done and the readable count) is due exactly one edge after the strobe that causes it. The bench drives each strobe for one cycle from a falling edge and checks at the following falling edge. rd_data is combinational, so the bench changes rd_sel and reads it a nanosecond later, with no edge in between. The done pulse is checked high at the falling edge right after the final handshake's edge and low one cycle later.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;
    localparam int CMD_FLAG_BIT = 7;
    localparam logic [6:0] OP_NOP   = 7'h00;
    localparam logic [6:0] OP_RESET = 7'h02;
    localparam logic [6:0] OP_XFER  = 7'h10;
endpackage

// File: rtl/xfer_count_shadow.sv
module xfer_count_shadow #(
    parameter int BYTE_W    = 8,
    parameter int CNT_BYTES = 3,
    localparam int CNT_W    = BYTE_W * CNT_BYTES,
    localparam int SEL_W    = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [CNT_W-1:0]  shadow,
    output logic              top_written,
    output logic              cnt_wr
);
    logic [BYTE_W-1:0] sh_d [CNT_BYTES];
    logic [BYTE_W-1:0] sh_q [CNT_BYTES];
    logic              wr_d, wr_q;
    logic              sel_ok;

    assign sel_ok = (32'(reg_sel) < CNT_BYTES);
    assign cnt_wr = reg_wr && sel_ok;

    always_comb begin
        wr_d = wr_q;
        for (int i = 0; i < CNT_BYTES; i++) begin
            sh_d[i] = sh_q[i];
        end
        if (soft_rst) begin
            wr_d = 1'b0;
            for (int i = 0; i < CNT_BYTES; i++) begin
                sh_d[i] = '0;
            end
        end else if (cnt_wr) begin
            for (int i = 0; i < CNT_BYTES; i++) begin
                if (32'(reg_sel) == i) begin
                    sh_d[i] = reg_wdata;
                end
            end
            if (32'(reg_sel) == CNT_BYTES - 1) begin
                wr_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            for (int i = 0; i < CNT_BYTES; i++) begin
                sh_q[i] <= '0;
            end
        end else begin
            wr_q <= wr_d;
            for (int i = 0; i < CNT_BYTES; i++) begin
                sh_q[i] <= sh_d[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < CNT_BYTES; g++) begin : g_pack
            assign shadow[g*BYTE_W +: BYTE_W] = sh_q[g];
        end
    endgenerate

    assign top_written = wr_q;
endmodule

// File: rtl/xfer_count_len.sv
module xfer_count_len #(
    parameter int CNT_W    = 24,
    parameter int ZERO_CNT = 65536,
    parameter int CMD_CAP  = 32
) (
    input  logic [CNT_W-1:0] shadow,
    input  logic [CNT_W-1:0] expect_bytes,
    input  logic             collect,
    output logic [CNT_W-1:0] eff,
    output logic [CNT_W-1:0] len
);
    logic [CNT_W-1:0] limit;

    always_comb begin
        eff   = (shadow == '0) ? CNT_W'(ZERO_CNT) : shadow;
        limit = collect ? CNT_W'(CMD_CAP) : expect_bytes;
        len   = (eff < limit) ? eff : limit;
    end
endmodule

// File: rtl/xfer_count_core.sv
module xfer_count_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cnt_wr,
    input  logic             cmd_wr,
    input  logic             cmd_dma,
    input  logic             cmd_xfer,
    input  logic [CNT_W-1:0] shadow,
    input  logic [CNT_W-1:0] eff,
    input  logic [CNT_W-1:0] len,
    input  logic             dma_ack,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] left,
    output logic             busy,
    output logic             tc,
    output logic             dma_mode,
    output logic             irq,
    output logic             cause_bs,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] left;
        logic             busy;
        logic             tc;
        logic             dma_mode;
        logic             irq;
        logic             cause_bs;
        logic             done;
    } state_t;

    state_t s_d, s_q;
    logic   finish;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        finish   = 1'b0;
        if (soft_rst) begin
            s_d = '0;
        end else begin
            if (cnt_wr) begin
                s_d.tc = 1'b0;
            end
            if (irq_clr) begin
                s_d.irq      = 1'b0;
                s_d.cause_bs = 1'b0;
            end
            if (dma_ack && s_q.busy) begin
                s_d.cnt  = s_q.cnt - CNT_W'(1);
                s_d.left = s_q.left - CNT_W'(1);
                finish   = (s_q.left == CNT_W'(1));
            end
            if (cmd_wr) begin
                finish       = 1'b0;
                s_d.dma_mode = cmd_dma;
                s_d.busy     = 1'b0;
                if (cmd_dma) begin
                    s_d.cnt = shadow;
                    if (cmd_xfer) begin
                        s_d.tc   = 1'b0;
                        s_d.cnt  = eff;
                        s_d.left = len;
                        if (len == '0) begin
                            finish = 1'b1;
                        end else begin
                            s_d.busy = 1'b1;
                        end
                    end
                end
            end
            if (finish) begin
                s_d.tc       = 1'b1;
                s_d.irq      = 1'b1;
                s_d.cause_bs = 1'b1;
                s_d.done     = 1'b1;
                s_d.busy     = 1'b0;
                s_d.cnt      = '0;
                s_d.left     = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt      = s_q.cnt;
    assign left     = s_q.left;
    assign busy     = s_q.busy;
    assign tc       = s_q.tc;
    assign dma_mode = s_q.dma_mode;
    assign irq      = s_q.irq;
    assign cause_bs = s_q.cause_bs;
    assign done     = s_q.done;
endmodule

// File: rtl/xfer_count_top.sv
module xfer_count_top #(
    parameter int          BYTE_W    = 8,
    parameter int          CNT_BYTES = 3,
    parameter int          ZERO_CNT  = 65536,
    parameter int          CMD_CAP   = 32,
    parameter logic [7:0]  CHIP_ID   = 8'hA2,
    localparam int         CNT_W     = BYTE_W * CNT_BYTES,
    localparam int         SEL_W     = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_byte,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  xfer_expect,
    input  logic              cmd_collect,
    input  logic              dma_ack,
    input  logic              irq_clr,
    output logic              tc,
    output logic              dma_mode,
    output logic              busy,
    output logic [CNT_W-1:0]  left,
    output logic              done,
    output logic              irq,
    output logic              cause_bs
);
    import xfer_count_pkg::*;

    logic             soft_rst, cmd_dma, cmd_xfer, cnt_wr, top_written;
    logic [CNT_W-1:0] shadow, eff, len, cnt;

    assign cmd_dma  = cmd_byte[CMD_FLAG_BIT];
    assign soft_rst = cmd_wr && (cmd_byte[6:0] == OP_RESET);
    assign cmd_xfer = (cmd_byte[6:0] == OP_XFER);

    xfer_count_shadow #(.BYTE_W(BYTE_W), .CNT_BYTES(CNT_BYTES)) u_shadow (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .shadow(shadow), .top_written(top_written), .cnt_wr(cnt_wr)
    );

    xfer_count_len #(.CNT_W(CNT_W), .ZERO_CNT(ZERO_CNT), .CMD_CAP(CMD_CAP)) u_len (
        .shadow(shadow), .expect_bytes(xfer_expect), .collect(cmd_collect),
        .eff(eff), .len(len)
    );

    xfer_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cnt_wr(cnt_wr),
        .cmd_wr(cmd_wr), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer),
        .shadow(shadow), .eff(eff), .len(len),
        .dma_ack(dma_ack), .irq_clr(irq_clr),
        .cnt(cnt), .left(left), .busy(busy), .tc(tc), .dma_mode(dma_mode),
        .irq(irq), .cause_bs(cause_bs), .done(done)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < CNT_BYTES; i++) begin
            if (32'(rd_sel) == i) begin
                rd_data = cnt[i*BYTE_W +: BYTE_W];
            end
        end
        if (32'(rd_sel) == CNT_BYTES - 1 && !top_written) begin
            rd_data = BYTE_W'(CHIP_ID);
        end
    end
endmodule

// File: rtl/xfer_count_chk.sv
module xfer_count_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             cmd_wr,
    input logic [7:0]       cmd_byte,
    input logic             dma_ack,
    input logic             irq_clr,
    input logic             tc,
    input logic             dma_mode,
    input logic             busy,
    input logic [CNT_W-1:0] left,
    input logic             done,
    input logic             irq,
    input logic             cause_bs
);
    // R2: a count byte write with no competing event leaves tc clear
    p_tc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !cmd_wr && !dma_ack |=> !tc);

    // R3: dma_mode follows the flag of the last non-reset command
    p_dma_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_byte[6:0] != 7'h02 |=> dma_mode == $past(cmd_byte[7]));

    // R7: accepted handshake lowers the remaining length by one
    p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && dma_ack && !cmd_wr |=> left == $past(left) - CNT_W'(1));

    // R7: handshake while idle changes nothing
    p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !cmd_wr |=> $stable(left) && !busy);

    // R8: completion pulse comes with its status
    p_done_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tc && irq && cause_bs && !busy && left == '0);

    // R9: interrupt clear drops irq and cause when no completion competes
    p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !dma_ack && !cmd_wr |=> !irq && !cause_bs);
endmodule

bind xfer_count_top xfer_count_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .cmd_wr(cmd_wr),
    .cmd_byte(cmd_byte), .dma_ack(dma_ack), .irq_clr(irq_clr), .tc(tc),
    .dma_mode(dma_mode), .busy(busy), .left(left), .done(done),
    .irq(irq), .cause_bs(cause_bs)
);

// File: tb/sim_xfer_count_top.sv
module sim_xfer_count_top;
    localparam logic [7:0] CHIP_ID = 8'hA2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic [23:0] xfer_expect = '0;
    logic        cmd_collect = 1'b0;
    logic        dma_ack = 1'b0;
    logic        irq_clr = 1'b0;
    logic        tc, dma_mode, busy, done, irq, cause_bs;
    logic [23:0] left;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xfer_count_top #(.CHIP_ID(CHIP_ID)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .rd_sel(rd_sel), .rd_data(rd_data), .xfer_expect(xfer_expect),
        .cmd_collect(cmd_collect), .dma_ack(dma_ack), .irq_clr(irq_clr),
        .tc(tc), .dma_mode(dma_mode), .busy(busy), .left(left), .done(done),
        .irq(irq), .cause_bs(cause_bs)
    );

    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  mid;
        logic [7:0]  hi;
        logic [7:0]  cmd;
        logic [23:0] expect_b;
        logic        collect;
        logic [7:0]  acks;
        logic [23:0] exp_left;
        logic [23:0] exp_cnt;
        logic        exp_tc;
        logic        exp_busy;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'h05, 8'h00, 8'h00, 8'h90, 24'd100,     1'b0, 8'd2,  24'd3,      24'd3,       1'b0, 1'b1}, // R5 R7 partial
        '{8'h10, 8'h00, 8'h00, 8'h90, 24'd4,       1'b0, 8'd4,  24'd0,      24'd0,       1'b1, 1'b0}, // R5 R8 expect limits
        '{8'h00, 8'h00, 8'h00, 8'h90, 24'h020000,  1'b0, 8'd3,  24'h00FFFD, 24'h00FFFD,  1'b0, 1'b1}, // R5 zero count
        '{8'h00, 8'h01, 8'h00, 8'h90, 24'd5,       1'b1, 8'd32, 24'd0,      24'd0,       1'b1, 1'b0}, // R6 cap 32
        '{8'h56, 8'h34, 8'h12, 8'h90, 24'd16,      1'b0, 8'd1,  24'd15,     24'h123455,  1'b0, 1'b1}, // R7 all bytes
        '{8'h03, 8'h00, 8'h00, 8'h10, 24'd50,      1'b0, 8'd2,  24'd15,     24'h123455,  1'b0, 1'b0}, // R10 no flag
        '{8'h02, 8'h00, 8'h00, 8'h90, 24'd0,       1'b0, 8'd0,  24'd0,      24'd0,       1'b1, 1'b0}, // R8 zero length
        '{8'h07, 8'h00, 8'h00, 8'h80, 24'd9,       1'b0, 8'd0,  24'd0,      24'd7,       1'b0, 1'b0}  // R3 reload only
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);
        cmd_wr = 1'b1; cmd_byte = c;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic ack();
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic rd_cnt(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        rd(2'd0, b0); rd(2'd1, b1); rd(2'd2, b2);
        v = {b2, b1, b0};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [23:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tc", tc, 0); chk("R1 irq", irq, 0); chk("R1 busy", busy, 0);
        chk("R1 dma_mode", dma_mode, 0); chk("R1 left", left, 0);
        chk("R1 cause_bs", cause_bs, 0); chk("R1 done", done, 0);
        rd(2'd0, b); chk("R1 lo", b, 0);
        rd(2'd1, b); chk("R1 mid", b, 0);
        rd(2'd2, b); chk("R4 hi id after reset", b, CHIP_ID);

        // vector table
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VEC[i].lo); wr(2'd1, VEC[i].mid); wr(2'd2, VEC[i].hi);
            xfer_expect = VEC[i].expect_b;
            cmd_collect = VEC[i].collect;
            cmd(VEC[i].cmd);
            for (int k = 0; k < int'(VEC[i].acks); k++) ack();
            chk($sformatf("vec%0d left R5 R6 R7", i), left, VEC[i].exp_left);
            chk($sformatf("vec%0d tc R8", i), tc, VEC[i].exp_tc);
            chk($sformatf("vec%0d busy R10", i), busy, VEC[i].exp_busy);
            rd_cnt(c);
            chk($sformatf("vec%0d count R3 R7", i), c, VEC[i].exp_cnt);
        end
        cmd_collect = 1'b0;

        // R8 done pulse and completion status
        wr(2'd0, 8'd2); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
        xfer_expect = 24'd10;
        cmd(8'h90);
        chk("R3 dma_mode set", dma_mode, 1);
        ack();
        chk("R8 no done early", done, 0);
        chk("R7 busy mid", busy, 1);
        ack();
        chk("R8 done pulse", done, 1);
        chk("R8 irq", irq, 1);
        chk("R8 cause_bs", cause_bs, 1);
        chk("R8 tc", tc, 1);
        rd_cnt(c); chk("R8 count zero", c, 0);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);

        // R9 interrupt clear
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk("R9 irq cleared", irq, 0);
        chk("R9 cause cleared", cause_bs, 0);
        chk("R9 tc kept", tc, 1);

        // R7 ack while idle ignored
        ack();
        chk("R7 idle ack left", left, 0);
        rd_cnt(c); chk("R7 idle ack count", c, 0);

        // R2 write clears tc, shadow invisible
        wr(2'd0, 8'h55);
        chk("R2 tc cleared", tc, 0);
        rd(2'd0, b); chk("R2 lo unchanged", b, 0);

        // R4 soft reset restores identification
        cmd(8'h02);
        rd(2'd2, b); chk("R4 hi id after soft reset", b, CHIP_ID);
        chk("R4 dma_mode after soft reset", dma_mode, 0);
        wr(2'd0, 8'h11);
        rd(2'd2, b); chk("R4 hi id after lo write", b, CHIP_ID);
        wr(2'd2, 8'h33);
        rd(2'd2, b); chk("R4 hi reads count after write", b, 8'h00);
        cmd(8'h80);
        rd(2'd2, b); chk("R3 hi reloaded", b, 8'h33);
        rd(2'd0, b); chk("R3 lo reloaded", b, 8'h11);
        chk("R3 no start on nop", busy, 0);

        // R6 cap with count below 32
        wr(2'd0, 8'd10); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
        cmd_collect = 1'b1; xfer_expect = 24'd1;
        cmd(8'h90);
        chk("R6 small count under cap", left, 10);
        cmd_collect = 1'b0;

        // R3 non-flag command stops transfer
        cmd(8'h00);
        chk("R3 dma_mode cleared", dma_mode, 0);
        chk("R3 transfer stopped", busy, 0);
        chk("R3 stop no irq", irq, 0);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule